// File: doc/BRIEF.md
# Per-Line Sprite Selection Scanner

At the start of every display line, this block walks an object attribute table of 40 entries. It picks out the objects whose vertical span covers the current line and keeps up to ten of them. The kept objects stay ordered by horizontal position. The table is read one 4-byte entry at a time through a synchronous read port. Data returns one clock after the request. Each object takes two clocks, one to request and one to evaluate, so the whole table is covered in an 80-clock window.

Each accepted object goes straight into its sorted place in a ten-slot register list. All later slots shift in the same clock. Once scanning ends, the pixel pipeline reads the leftmost held object from the head outputs. A hit flag tells the pipeline that this object begins at the current pixel position. A pop pulse removes the head so the next object moves up.

Top module: `spr_line_scan`

## Requirements
- R1: After reset, busy, read enable, head valid and head hit are all low, and the held count is 0.
- R2: A start pulse begins a scan in the next clock. Entry i is requested at byte address 4*i in clock 2*i after the start edge. Read enable is high only on those clocks. Busy drops exactly 80 clocks after the start edge.
- R3: With the height select low, an entry is kept when line+16 >= Y and line+16 < Y+8. Both sides are computed without wrap.
- R4: With the height select high, the same test uses a height of 16.
- R5: Held objects come out in ascending X order. Objects with equal X keep their table order, earlier entry first.
- R6: At most 10 objects are held. After that, matching entries later in the table are dropped, and the count never grows by more than one per clock.
- R7: A pop pulse while idle with a non-empty list removes the head and lowers the count by one. A pop on an empty list, or while busy, changes nothing.
- R8: Head hit is high exactly when an object is held and its X equals the pixel position input plus 8, compared in 9 bits.
- R9: A start pulse empties the list at the next clock edge, whatever it held. This includes a start that arrives during a scan, which restarts the walk from entry 0.
- R10: Each read word carries Y in bits 7:0, X in bits 15:8, the tile index in bits 23:16 and the attribute byte in bits 31:24. The head outputs present these fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Line start strobe |
| line_i | input | 8 | Current line number |
| tall_i | input | 1 | Height select: 1 gives 16 rows, 0 gives 8 |
| rd_en_o | output | 1 | Table read request |
| rd_addr_o | output | 8 | Byte address of the requested entry |
| rd_data_i | input | 32 | Entry word, valid one clock after the request |
| busy_o | output | 1 | Scan in progress |
| sel_count_o | output | 4 | Number of held objects |
| head_valid_o | output | 1 | At least one object held |
| head_y_o | output | 8 | Head object Y |
| head_x_o | output | 8 | Head object X |
| head_tile_o | output | 8 | Head object tile index |
| head_attr_o | output | 8 | Head object attributes |
| pix_x_i | input | 8 | Current pixel position |
| head_hit_o | output | 1 | Head object starts at this pixel |
| pop_i | input | 1 | Remove the head object |

## Verification
The assertions check several rules on every clock:
- the count bound and the one-step growth limit;
- the alignment and alternating pacing of read requests;
- the clearing effect of a start;
- the count effects of pop: it lowers the count when idle, leaves an empty list alone, and is ignored during a scan;
- the hit flag is never raised without a held object.

Only the bench scenarios can show the parts that depend on the table contents. These are:
- which entries the height test keeps;
- the stable X ordering, including ties;
- which ten objects survive when too many match;
- the exact fields at the head.

The bench checks these against a separately written reference model, over several table patterns, lines and both heights.

// File: rtl/spr_scan_pkg.sv
package spr_scan_pkg;
  localparam int BYTE_W = 8;

  // One table entry; the packed order places Y in the low byte of a read word.
  typedef struct packed {
    logic [BYTE_W-1:0] attr;
    logic [BYTE_W-1:0] tile;
    logic [BYTE_W-1:0] x;
    logic [BYTE_W-1:0] y;
  } spr_obj_t;

  localparam int OBJ_W = $bits(spr_obj_t);
endpackage

// File: rtl/spr_rst_sync.sv
module spr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/spr_scan_ctrl.sv
module spr_scan_ctrl #(
  parameter int NUM_OBJ = 40,
  localparam int IDX_W  = $clog2(NUM_OBJ),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              eval_o,
  output logic              busy_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ph_q, ph_d;
  logic             busy_q, busy_d;
  logic             ctl_en;

  always_comb begin
    idx_d  = idx_q;
    ph_d   = ph_q;
    busy_d = busy_q;
    ctl_en = 1'b0;
    if (start_i) begin
      ctl_en = 1'b1;
      idx_d  = '0;
      ph_d   = 1'b0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      ctl_en = 1'b1;
      if (!ph_q) begin
        ph_d = 1'b1;
      end else begin
        ph_d = 1'b0;
        if (idx_q == IDX_W'(NUM_OBJ - 1)) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (ctl_en) begin
      idx_q  <= idx_d;
      ph_q   <= ph_d;
      busy_q <= busy_d;
    end
  end

  assign rd_en_o   = busy_q && !ph_q;
  assign rd_addr_o = {idx_q, 2'b00};
  assign eval_o    = busy_q && ph_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/spr_hit_test.sv
module spr_hit_test #(
  parameter int LINE_OFS = 16,
  parameter int SHORT_H  = 8,
  parameter int TALL_H   = 16
) (
  input  logic [7:0] line_i,
  input  logic       tall_i,
  input  logic [7:0] y_i,
  output logic       hit_o
);
  logic [8:0] probe;
  logic [8:0] top;

  always_comb begin
    probe = {1'b0, line_i} + 9'(LINE_OFS);
    top   = {1'b0, y_i} + (tall_i ? 9'(TALL_H) : 9'(SHORT_H));
    hit_o = (probe >= {1'b0, y_i}) && (probe < top);
  end
endmodule

// File: rtl/spr_sort_list.sv
module spr_sort_list
  import spr_scan_pkg::*;
#(
  parameter int MAX_SEL = 10,
  localparam int CNT_W  = $clog2(MAX_SEL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ins_i,
  input  spr_obj_t         ins_obj_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output spr_obj_t         head_o
);
  spr_obj_t         ent_q [MAX_SEL];
  spr_obj_t         ent_d [MAX_SEL];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [MAX_SEL-1:0] le_vec;
  logic [CNT_W-1:0] pos;
  logic             full, accept, pop_ok, ent_we, cnt_we;

  // Slot k counts toward the insert position when it is held and its X is not greater.
  for (genvar k = 0; k < MAX_SEL; k++) begin : g_cmp
    assign le_vec[k] = (CNT_W'(k) < cnt_q) && (ent_q[k].x <= ins_obj_i.x);
  end

  always_comb begin
    pos = '0;
    for (int k = 0; k < MAX_SEL; k++) begin
      pos = pos + CNT_W'(le_vec[k]);
    end
  end

  assign full   = (cnt_q == CNT_W'(MAX_SEL));
  assign accept = ins_i && !full && !clr_i;
  assign pop_ok = pop_i && (cnt_q != '0) && !clr_i && !ins_i;

  always_comb begin
    for (int k = 0; k < MAX_SEL; k++) begin
      ent_d[k] = ent_q[k];
    end
    cnt_d  = cnt_q;
    ent_we = 1'b0;
    cnt_we = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_we = 1'b1;
    end else if (accept) begin
      ent_we = 1'b1;
      cnt_we = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      for (int k = 1; k < MAX_SEL; k++) begin
        if (k > int'(pos)) ent_d[k] = ent_q[k-1];
      end
      for (int k = 0; k < MAX_SEL; k++) begin
        if (k == int'(pos)) ent_d[k] = ins_obj_i;
      end
    end else if (pop_ok) begin
      ent_we = 1'b1;
      cnt_we = 1'b1;
      cnt_d  = cnt_q - 1'b1;
      for (int k = 0; k < MAX_SEL - 1; k++) begin
        ent_d[k] = ent_q[k+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_SEL; k++) ent_q[k] <= '0;
    end else if (ent_we) begin
      for (int k = 0; k < MAX_SEL; k++) ent_q[k] <= ent_d[k];
    end
  end

  assign cnt_o  = cnt_q;
  assign head_o = ent_q[0];
endmodule

// File: rtl/spr_line_scan.sv
module spr_line_scan
  import spr_scan_pkg::*;
#(
  parameter int NUM_OBJ  = 40,
  parameter int MAX_SEL  = 10,
  parameter int LINE_OFS = 16,
  parameter int PIX_OFS  = 8,
  localparam int IDX_W   = $clog2(NUM_OBJ),
  localparam int ADDR_W  = IDX_W + 2,
  localparam int CNT_W   = $clog2(MAX_SEL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        line_i,
  input  logic              tall_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [OBJ_W-1:0]  rd_data_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  sel_count_o,
  output logic              head_valid_o,
  output logic [7:0]        head_y_o,
  output logic [7:0]        head_x_o,
  output logic [7:0]        head_tile_o,
  output logic [7:0]        head_attr_o,
  input  logic [7:0]        pix_x_i,
  output logic              head_hit_o,
  input  logic              pop_i
);
  logic     rst_n_s;
  logic     eval, match, busy;
  spr_obj_t rd_obj, head;

  spr_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  spr_scan_ctrl #(.NUM_OBJ(NUM_OBJ)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start_i),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .eval_o    (eval),
    .busy_o    (busy)
  );

  assign rd_obj = spr_obj_t'(rd_data_i);

  spr_hit_test #(.LINE_OFS(LINE_OFS)) u_hit (
    .line_i (line_i),
    .tall_i (tall_i),
    .y_i    (rd_obj.y),
    .hit_o  (match)
  );

  spr_sort_list #(.MAX_SEL(MAX_SEL)) u_list (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr_i     (start_i),
    .ins_i     (eval && match),
    .ins_obj_i (rd_obj),
    .pop_i     (pop_i && !busy),
    .cnt_o     (sel_count_o),
    .head_o    (head)
  );

  assign busy_o       = busy;
  assign head_valid_o = (sel_count_o != '0);
  assign head_y_o     = head.y;
  assign head_x_o     = head.x;
  assign head_tile_o  = head.tile;
  assign head_attr_o  = head.attr;
  assign head_hit_o   = head_valid_o &&
                        ({1'b0, head.x} == ({1'b0, pix_x_i} + 9'(PIX_OFS)));
endmodule

// File: rtl/spr_scan_chk.sv
module spr_scan_chk #(
  parameter int MAX_SEL = 10,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pop_i,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  sel_count_o,
  input logic              head_valid_o,
  input logic              head_hit_o
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_count_o <= CNT_W'(MAX_SEL)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> int'(sel_count_o) <= int'($past(sel_count_o)) + 1); // R6
  AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> rd_addr_o[1:0] == 2'b00); // R2
  AST_RD_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o && !start_i |=> !rd_en_o); // R2
  AST_RD_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> sel_count_o == '0); // R9
  AST_POP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !busy_o && !start_i && sel_count_o != '0
    |=> sel_count_o == $past(sel_count_o) - 1'b1); // R7
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !busy_o && !start_i && sel_count_o == '0 |=> sel_count_o == '0); // R7
  AST_POP_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !start_i |=> sel_count_o >= $past(sel_count_o)); // R7
  AST_HIT_NEEDS_OBJ: assert property (@(posedge clk) disable iff (!rst_n)
    head_hit_o |-> head_valid_o); // R8
endmodule

bind spr_line_scan spr_scan_chk #(
  .MAX_SEL (MAX_SEL),
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .pop_i        (pop_i),
  .rd_en_o      (rd_en_o),
  .rd_addr_o    (rd_addr_o),
  .busy_o       (busy_o),
  .sel_count_o  (sel_count_o),
  .head_valid_o (head_valid_o),
  .head_hit_o   (head_hit_o)
);

// File: tb/test_spr_line_scan.sv
module test_spr_line_scan;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 40;
  localparam int NSEL = 10;
  localparam int NVEC = 10;
  // Vector: {pattern[1:0], line[7:0], tall}
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd0, 8'd0,   1'b0}, {2'd0, 8'd20,  1'b0}, {2'd0, 8'd20, 1'b1},
    {2'd0, 8'd150, 1'b1}, {2'd0, 8'd100, 1'b1}, {2'd1, 8'd7,  1'b0},
    {2'd1, 8'd8,   1'b0}, {2'd1, 8'd8,   1'b1}, {2'd2, 8'd0,  1'b1},
    {2'd3, 8'd50,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n, start, tall, pop, rd_en, busy, hv, hit;
  logic [7:0]  line, rd_addr, hy, hx, ht, ha, pix_x;
  logic [31:0] rd_data;
  logic [3:0]  cnt;
  logic [31:0] oam [NOBJ];
  int n_tests = 0;
  int n_fail = 0;
  int exp_n;
  int ex_y [NSEL];
  int ex_x [NSEL];
  int ex_t [NSEL];
  int ex_a [NSEL];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= oam[rd_addr[7:2]];

  spr_line_scan i_spr_line_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_i(line), .tall_i(tall),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .busy_o(busy),
    .sel_count_o(cnt), .head_valid_o(hv), .head_y_o(hy), .head_x_o(hx),
    .head_tile_o(ht), .head_attr_o(ha), .pix_x_i(pix_x), .head_hit_o(hit),
    .pop_i(pop)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] entry(input int pat, input int i);
    int y, x, t, a;
    case (pat)
      0: begin y = 16 + 4*i; x = (37*i) % 200; t = i; a = i ^ 8'h5A; end
      1: begin y = 16; x = 3*(40 - i); t = 8'h80 + i; a = i; end
      2: begin y = 16; x = (i % 3) * 10; t = i; a = 8'hC0 + i; end
      default: begin y = 0; x = i; t = i; a = 0; end
    endcase
    return {8'(a), 8'(t), 8'(x), 8'(y)};
  endfunction

  task automatic load(input int pat);
    for (int i = 0; i < NOBJ; i++) oam[i] = entry(pat, i);
  endtask

  // Reference selection: height test, cap, stable insertion by X.
  task automatic model(input int pat, input int ln, input bit tl);
    int h, pos;
    logic [31:0] w;
    h = tl ? 16 : 8;
    exp_n = 0;
    for (int i = 0; i < NOBJ; i++) begin
      w = entry(pat, i);
      if (exp_n < NSEL && ln + 16 >= int'(w[7:0]) && ln + 16 < int'(w[7:0]) + h) begin
        pos = exp_n;
        for (int k = exp_n - 1; k >= 0; k--) if (ex_x[k] > int'(w[15:8])) pos = k;
        for (int k = exp_n; k > pos; k--) begin
          ex_y[k] = ex_y[k-1]; ex_x[k] = ex_x[k-1];
          ex_t[k] = ex_t[k-1]; ex_a[k] = ex_a[k-1];
        end
        ex_y[pos] = w[7:0];   ex_x[pos] = w[15:8];
        ex_t[pos] = w[23:16]; ex_a[pos] = w[31:24];
        exp_n++;
      end
    end
  endtask

  task automatic scan(input int ln, input bit tl);
    line = 8'(ln); tall = tl; start = 1'b1;
    tick();
    start = 1'b0;
    repeat (80) tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tall = 1'b0; pop = 1'b0; line = '0; pix_x = '0;
    load(3);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "rd_en", rd_en, 0);
    chk("R1", "count", cnt, 0);
    chk("R1", "head_valid", hv, 0);
    chk("R1", "head_hit", hit, 0);

    // R2 pacing and addresses
    load(0);
    line = 8'd20; tall = 1'b0; start = 1'b1;
    tick();
    start = 1'b0;
    chk("R2", "busy after start", busy, 1);
    for (int i = 0; i < NOBJ; i++) begin
      chk("R2", "rd_en request clock", rd_en, 1);
      chk("R2", "rd_addr", rd_addr, 4*i);
      tick();
      chk("R2", "rd_en eval clock", rd_en, 0);
      tick();
    end
    chk("R2", "busy after 80 clocks", busy, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      int pat, ln;
      bit tl;
      string rq;
      pat = int'(VEC[v][10:9]); ln = int'(VEC[v][8:1]); tl = VEC[v][0];
      rq = (pat == 1) ? "R6" : (pat == 2) ? "R5" : tl ? "R4" : "R3";
      load(pat);
      model(pat, ln, tl);
      scan(ln, tl);
      chk("R2", "scan finished", busy, 0);
      chk(rq, "held count", cnt, exp_n);
      for (int k = 0; k < exp_n; k++) begin
        chk("R7", "head valid", hv, 1);
        chk("R5", "head x order", hx, ex_x[k]);
        chk("R10", "head y", hy, ex_y[k]);
        chk("R10", "head tile", ht, ex_t[k]);
        chk("R10", "head attr", ha, ex_a[k]);
        if (ex_x[k] >= 8) begin
          pix_x = 8'(ex_x[k] - 8); #1;
          chk("R8", "hit at x-8", hit, 1);
          pix_x = 8'(ex_x[k] - 7); #1;
          chk("R8", "no hit at x-7", hit, 0);
        end
        pop = 1'b1; tick(); pop = 1'b0;
        chk("R7", "count after pop", cnt, exp_n - k - 1);
      end
      chk("R7", "list drained", hv, 0);
      chk("R8", "no hit when empty", hit, 0);
    end

    // R7 pop on empty list
    pop = 1'b1; tick(); pop = 1'b0;
    chk("R7", "pop empty count", cnt, 0);
    chk("R7", "pop empty valid", hv, 0);

    // R7 pop ignored while busy; R9 clear on start
    load(1);
    scan(7, 1'b0);
    chk("R6", "full list", cnt, 10);
    line = 8'd7; start = 1'b1;
    tick();
    start = 1'b0;
    chk("R9", "count cleared by start", cnt, 0);
    pop = 1'b1;
    repeat (80) tick();
    pop = 1'b0;
    chk("R7", "pops during scan ignored", cnt, 10);
    chk("R5", "head after ignored pops", hx, 3*(40 - 9));

    // R9 restart mid-scan
    start = 1'b1; tick(); start = 1'b0;
    repeat (10) tick();
    start = 1'b1; tick(); start = 1'b0;
    repeat (79) tick();
    chk("R9", "restart still busy", busy, 1);
    tick();
    chk("R9", "restart done", busy, 0);
    chk("R9", "restart count", cnt, 10);

    // R9 new line with no matches clears held list
    load(3);
    scan(50, 1'b1);
    chk("R9", "empty after new line", cnt, 0);
    chk("R3", "no match head valid", hv, 0);

    finish_run();
  end
endmodule